// File: doc/BRIEF.md
# Memory Gap Decoder

This block decides where a physical memory access goes when parts of extended memory are handed over to devices on the PCI bus. Three programmable holes (a low gap, a middle gap and a high gap) can each be placed on a 1 Mbyte boundary with a power-of-two size from 1 to 32 Mbytes. An address that falls inside an enabled hole is claimed for the PCI bus. Any other address below the installed top of memory is claimed for DRAM at the same address.

The DRAM that sits under a hole is not normally reachable. When reclaim is switched on, a window of the same total size opens directly above the top of memory. Addresses in that window are redirected onto the hidden DRAM, filling the holes in ascending gap order. The decode is purely combinational on the address. The configuration sits in registers that a write strobe loads. An error flag reports layouts that break the placement rules.

Top module: `memgap_decoder`

## Requirements
- R1: After reset all gaps and reclaim are disabled and the top of memory is 0, so no address produces `pci_hit` or `dram_hit`, `dram_addr` is 0 and `cfg_err` is 0.
- R2: A write with `cfg_we` high is taken at the rising clock edge and shapes the outputs from that edge onward. `cfg_sel` 0, 1 and 2 select the low, middle and high gap, with `cfg_wdata[11:0]` the base in Mbytes, `[14:12]` the size code and `[15]` the enable. `cfg_sel` 3 holds `[11:0]` the top of memory in Mbytes and `[15]` the reclaim enable. `cfg_sel` 4 to 7 change nothing.
- R3: Size code n (0 to 5) gives a gap of 2^n Mbytes. An address whose bits [31:20] lie in [base, base+2^n) of an enabled gap raises `pci_hit`.
- R4: Size codes 6 and 7 are invalid. An enabled gap with such a code never matches and raises `cfg_err`.
- R5: An enabled gap raises `cfg_err` when its base is not a multiple of its size or when its base is 0, which would place it below 1 Mbyte.
- R6: Enabled gaps must be in ascending, non-overlapping order: low before middle before high. A gap whose end exceeds the base of a later enabled gap raises `cfg_err`. Disabled gaps take no part in this check.
- R7: An address below the top of memory and outside every enabled gap gives `dram_hit` with `dram_addr` equal to the address.
- R8: `pci_hit` and `dram_hit` are never high together. A gap match wins over both plain DRAM and the reclaim window.
- R9: With reclaim off, an address at or above the top of memory and outside every gap gives neither hit.
- R10: With reclaim on, H is the sum over enabled gaps of the part of each gap below the top of memory. Offset k = address_MB − top in [0, H) maps to the k-th hidden Mbyte, with gaps taken low, middle, high. `dram_addr` keeps the address bits [19:0].
- R11: `dram_addr` is 0 whenever `dram_hit` is low.
- R12: A disabled gap has no effect on decode or on the reclaim window size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| addr | input | 32 | Physical byte address to decode |
| pci_hit | output | 1 | Address belongs to an enabled gap |
| dram_hit | output | 1 | Address is served by DRAM |
| dram_addr | output | 32 | Translated DRAM address, 0 when no DRAM hit |
| cfg_err | output | 1 | Configuration breaks a size, alignment or ordering rule |

## Verification
A gap match and a reclaim-window match can fall on the same address in the same cycle. This happens when a gap sits at or just above the top of memory. The bench provokes it by placing the high gap right at the top with reclaim on. It expects `pci_hit` alone on addresses inside that gap, and a translated DRAM hit on the next reclaim Mbytes past the gap. A configuration write and a decode can also share a cycle. This is judged by probing the same address just before and just after the write edge.

// File: rtl/memgap_pkg.sv
// Package: shared constants for the memory gap decoder.
// Assumes one configuration word per register and 1 Mbyte granularity.
package memgap_pkg;
    localparam int MB_SHIFT      = 20;  // byte address bits inside one Mbyte
    localparam int SZ_CODE_W     = 3;   // width of a gap size code
    localparam int MAX_SIZE_CODE = 5;   // code 5 = 32 Mbytes, larger is invalid
    localparam int SEL_W         = 3;   // width of the register select
    localparam int GAP_COUNT     = 3;   // low, middle, high
    localparam int SEL_TOP       = 3;   // select value of the top/reclaim word
endpackage

// File: rtl/memgap_cfg_regs.sv
// Configuration register file: one word per gap plus a top-of-memory word.
// Word layout: [MB_W-1:0] Mbyte value, [MB_W+2:MB_W] size code, [MB_W+3] enable.
// Assumes a single write port; selects outside 0..GAP_N are ignored.
module memgap_cfg_regs
    import memgap_pkg::*;
#(
    parameter int MB_W  = 12,
    parameter int GAP_N = GAP_COUNT,
    localparam int CFG_W = MB_W + SZ_CODE_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SEL_W-1:0]     sel,
    input  logic [CFG_W-1:0]     wdata,
    output logic [MB_W-1:0]      gap_base [GAP_N],
    output logic [SZ_CODE_W-1:0] gap_code [GAP_N],
    output logic                 gap_en   [GAP_N],
    output logic [MB_W-1:0]      top_mb,
    output logic                 reclaim_en
);
    localparam int EN_BIT = CFG_W - 1;

    for (genvar g = 0; g < GAP_N; g++) begin : g_gap
        // Load one gap word when its select is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gap_base[g] <= '0;
                gap_code[g] <= '0;
                gap_en[g]   <= 1'b0;
            end else if (we && sel == SEL_W'(g)) begin
                gap_base[g] <= wdata[MB_W-1:0];
                gap_code[g] <= wdata[MB_W +: SZ_CODE_W];
                gap_en[g]   <= wdata[EN_BIT];
            end
        end
    end

    // Load the top-of-memory word; its size-code field is unused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_mb     <= '0;
            reclaim_en <= 1'b0;
        end else if (we && sel == SEL_W'(GAP_N)) begin
            top_mb     <= wdata[MB_W-1:0];
            reclaim_en <= wdata[EN_BIT];
        end
    end

    logic unused_code;
    assign unused_code = ^wdata[MB_W +: SZ_CODE_W];
endmodule

// File: rtl/memgap_window.sv
// One gap window: match test, rule check, end address and hidden DRAM amount.
// All quantities are in Mbytes. Assumes top_mb is the installed DRAM size.
module memgap_window
    import memgap_pkg::*;
#(
    parameter int MB_W = 12,
    localparam int EW  = MB_W + 3
) (
    input  logic [MB_W-1:0]      addr_mb,
    input  logic [MB_W-1:0]      base,
    input  logic [SZ_CODE_W-1:0] code,
    input  logic                 en,
    input  logic [MB_W-1:0]      top_mb,
    output logic                 hit,
    output logic                 active,
    output logic                 bad,
    output logic [EW-1:0]        end_mb,
    output logic [EW-1:0]        hidden_mb
);
    logic            valid;
    logic [MB_W-1:0] mask;
    logic [EW-1:0]   base_x, top_x, size_x, lim_x;

    // Decode the size code into a low-bit mask and a size.
    always_comb begin
        valid  = code <= SZ_CODE_W'(MAX_SIZE_CODE);
        mask   = valid ? ((MB_W'(1) << code) - MB_W'(1)) : '0;
        size_x = EW'(mask) + EW'(1);
        base_x = EW'(base);
        top_x  = EW'(top_mb);
        end_mb = base_x + size_x;
    end

    // Match the address and flag broken placement of this gap.
    always_comb begin
        active = en && valid;
        hit    = active && ((addr_mb & ~mask) == (base & ~mask));
        bad    = en && (!valid || (base & mask) != '0 || base == '0);
    end

    // Amount of DRAM this gap covers below the top of memory.
    always_comb begin
        lim_x     = (end_mb < top_x) ? end_mb : top_x;
        hidden_mb = (active && base_x < top_x) ? (lim_x - base_x) : '0;
    end
endmodule

// File: rtl/memgap_reclaim.sv
// Reclaim window: maps Mbytes just above the top of memory onto DRAM hidden
// under the gaps, filling gaps in index order. Assumes gaps are ordered.
module memgap_reclaim
    import memgap_pkg::*;
#(
    parameter int MB_W  = 12,
    parameter int GAP_N = GAP_COUNT,
    localparam int EW   = MB_W + 3
) (
    input  logic [MB_W-1:0] addr_mb,
    input  logic [MB_W-1:0] top_mb,
    input  logic            reclaim_en,
    input  logic [MB_W-1:0] gap_base  [GAP_N],
    input  logic [EW-1:0]   hidden_mb [GAP_N],
    output logic            in_win,
    output logic [MB_W-1:0] xl_mb
);
    logic [EW-1:0] off;
    logic [EW-1:0] total;

    // Walk the gaps, tracking the prefix sum of hidden Mbytes.
    always_comb begin
        logic [EW-1:0] acc;
        off   = EW'(addr_mb) - EW'(top_mb);
        acc   = '0;
        xl_mb = '0;
        for (int i = 0; i < GAP_N; i++) begin
            if (off >= acc && off < acc + hidden_mb[i]) begin
                xl_mb = MB_W'(EW'(gap_base[i]) + off - acc);
            end
            acc = acc + hidden_mb[i];
        end
        total = acc;
    end

    // The window is open only with reclaim on and above the top of memory.
    always_comb begin
        in_win = reclaim_en && (addr_mb >= top_mb) && (off < total);
    end
endmodule

// File: rtl/memgap_decoder.sv
// Top of the memory gap decoder: registers the configuration, runs three gap
// windows and the reclaim window, and merges them into PCI/DRAM decisions.
// Assumes byte addresses; decode is combinational on addr.
module memgap_decoder
    import memgap_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int MB_W  = ADDR_W - MB_SHIFT,
    localparam int EW    = MB_W + 3,
    localparam int CFG_W = MB_W + SZ_CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [ADDR_W-1:0] addr,
    output logic              pci_hit,
    output logic              dram_hit,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              cfg_err
);
    localparam int GAP_N = GAP_COUNT;

    logic [MB_W-1:0]      gap_base  [GAP_N];
    logic [SZ_CODE_W-1:0] gap_code  [GAP_N];
    logic                 gap_en    [GAP_N];
    logic [MB_W-1:0]      top_mb;
    logic                 reclaim_en;
    logic [GAP_N-1:0]     hit, active, bad;
    logic [EW-1:0]        end_mb    [GAP_N];
    logic [EW-1:0]        hidden_mb [GAP_N];
    logic [MB_W-1:0]      addr_mb, xl_mb;
    logic                 in_win, below_top, order_bad;

    assign addr_mb = addr[ADDR_W-1:MB_SHIFT];

    memgap_cfg_regs #(.MB_W(MB_W), .GAP_N(GAP_N)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .sel        (cfg_sel),
        .wdata      (cfg_wdata),
        .gap_base   (gap_base),
        .gap_code   (gap_code),
        .gap_en     (gap_en),
        .top_mb     (top_mb),
        .reclaim_en (reclaim_en)
    );

    for (genvar g = 0; g < GAP_N; g++) begin : g_win
        memgap_window #(.MB_W(MB_W)) u_win (
            .addr_mb   (addr_mb),
            .base      (gap_base[g]),
            .code      (gap_code[g]),
            .en        (gap_en[g]),
            .top_mb    (top_mb),
            .hit       (hit[g]),
            .active    (active[g]),
            .bad       (bad[g]),
            .end_mb    (end_mb[g]),
            .hidden_mb (hidden_mb[g])
        );
    end

    memgap_reclaim #(.MB_W(MB_W), .GAP_N(GAP_N)) u_reclaim (
        .addr_mb    (addr_mb),
        .top_mb     (top_mb),
        .reclaim_en (reclaim_en),
        .gap_base   (gap_base),
        .hidden_mb  (hidden_mb),
        .in_win     (in_win),
        .xl_mb      (xl_mb)
    );

    // Check that every enabled gap ends before any later enabled gap starts.
    always_comb begin
        order_bad = 1'b0;
        for (int i = 0; i < GAP_N; i++) begin
            for (int j = i + 1; j < GAP_N; j++) begin
                if (active[i] && active[j] && end_mb[i] > EW'(gap_base[j])) begin
                    order_bad = 1'b1;
                end
            end
        end
    end

    // Merge gap, plain DRAM and reclaim decisions; gaps take priority.
    always_comb begin
        below_top = addr_mb < top_mb;
        pci_hit   = |hit;
        dram_hit  = !pci_hit && (below_top || in_win);
        if (!dram_hit)      dram_addr = '0;
        else if (below_top) dram_addr = addr;
        else                dram_addr = {xl_mb, addr[MB_SHIFT-1:0]};
        cfg_err   = (|bad) || order_bad;
    end
endmodule

// File: rtl/memgap_decoder_chk.sv
// Checker for the memory gap decoder, watching only the top-level ports.
module memgap_decoder_chk
    import memgap_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int MB_W  = ADDR_W - MB_SHIFT,
    localparam int CFG_W = MB_W + SZ_CODE_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [SEL_W-1:0]  cfg_sel,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic [ADDR_W-1:0] addr,
    input logic              pci_hit,
    input logic              dram_hit,
    input logic [ADDR_W-1:0] dram_addr,
    input logic              cfg_err
);
    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pci_hit && dram_hit));

    assert_zero_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_hit |-> dram_addr == '0);

    assert_low_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dram_hit |-> dram_addr[MB_SHIFT-1:0] == addr[MB_SHIFT-1:0]);

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_err));

    assert_bad_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel > SEL_W'(SEL_TOP)) |=> $stable(cfg_err));

    assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_hit && !cfg_err) |-> addr[ADDR_W-1:MB_SHIFT] != '0);
endmodule

bind memgap_decoder memgap_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .addr      (addr),
    .pci_hit   (pci_hit),
    .dram_hit  (dram_hit),
    .dram_addr (dram_addr),
    .cfg_err   (cfg_err)
);

// File: tb/memgap_decoder_test.sv
module memgap_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [31:0] addr = '0;
    logic        pci_hit, dram_hit, cfg_err;
    logic [31:0] dram_addr;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    memgap_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .addr(addr), .pci_hit(pci_hit),
        .dram_hit(dram_hit), .dram_addr(dram_addr), .cfg_err(cfg_err)
    );

    function automatic logic [15:0] word(input logic en, input logic [2:0] code,
                                         input logic [11:0] mb);
        return {en, code, mb};
    endfunction

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a, input logic e_pci, input logic e_dram,
                         input logic [31:0] e_addr, input string req);
        addr = a;
        #1;
        n_chk++;
        if (pci_hit !== e_pci || dram_hit !== e_dram || dram_addr !== e_addr) begin
            n_bad++;
            $display("FAIL %s addr=%h: pci=%b dram=%b daddr=%h, expected pci=%b dram=%b daddr=%h",
                     req, a, pci_hit, dram_hit, dram_addr, e_pci, e_dram, e_addr);
        end
    endtask

    task automatic chk_err(input logic e_err, input string req);
        #1;
        n_chk++;
        if (cfg_err !== e_err) begin
            n_bad++;
            $display("FAIL %s cfg_err=%b, expected %b", req, cfg_err, e_err);
        end
    endtask

    // R1: reset state.
    task automatic t_reset();
        chk_err(1'b0, "R1");
        probe(32'h0000_0000, 0, 0, 32'h0, "R1");
        probe(32'h0050_0000, 0, 0, 32'h0, "R1");
    endtask

    // R2, R7, R9: top write timing, plain DRAM, no reclaim.
    task automatic t_top();
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd3; cfg_wdata = word(0, 0, 12'd64);
        probe(32'h0100_0000, 0, 0, 32'h0, "R2 before edge");
        @(posedge clk);
        probe(32'h0100_0000, 0, 1, 32'h0100_0000, "R2 after edge");
        @(negedge clk);
        cfg_we = 1'b0;
        probe(32'h0123_4567, 0, 1, 32'h0123_4567, "R7");
        probe(32'h0400_0000, 0, 0, 32'h0, "R9");
    endtask

    // R3, R8: three gaps of distinct sizes.
    task automatic t_gaps();
        wr(3'd0, word(1, 3'd1, 12'd2));
        wr(3'd1, word(1, 3'd2, 12'd8));
        wr(3'd2, word(1, 3'd3, 12'd32));
        chk_err(1'b0, "R3");
        probe(32'h0028_0000, 1, 0, 32'h0, "R3 low");
        probe(32'h0040_0000, 0, 1, 32'h0040_0000, "R7 past low");
        probe(32'h00BF_FFFF, 1, 0, 32'h0, "R3 mid top edge");
        probe(32'h00C0_0000, 0, 1, 32'h00C0_0000, "R7 past mid");
        probe(32'h027F_FFFF, 1, 0, 32'h0, "R8 high");
        probe(32'h0280_0000, 0, 1, 32'h0280_0000, "R7 past high");
    endtask

    // R10: reclaim fills low, then middle, then high gap.
    task automatic t_reclaim();
        wr(3'd3, word(1, 0, 12'd64));
        probe(32'h0400_0123, 0, 1, 32'h0020_0123, "R10 k0");
        probe(32'h0420_0000, 0, 1, 32'h0080_0000, "R10 k2");
        probe(32'h0450_0010, 0, 1, 32'h00B0_0010, "R10 k5");
        probe(32'h0460_0000, 0, 1, 32'h0200_0000, "R10 k6");
        probe(32'h04D0_0000, 0, 1, 32'h0270_0000, "R10 k13");
        probe(32'h04E0_0000, 0, 0, 32'h0, "R10 k14");
    endtask

    // R8, R10: gap at the top overlaps the reclaim window.
    task automatic t_overlap();
        wr(3'd2, word(1, 3'd2, 12'd64));
        probe(32'h0400_0000, 1, 0, 32'h0, "R8 gap over reclaim");
        probe(32'h0430_0000, 1, 0, 32'h0, "R8 gap over reclaim");
        probe(32'h0440_0040, 0, 1, 32'h00A0_0040, "R10 k4");
        probe(32'h0460_0000, 0, 0, 32'h0, "R10 past H");
    endtask

    // R12: disabling the middle gap frees its range and shrinks H.
    task automatic t_disable();
        wr(3'd1, word(0, 3'd2, 12'd8));
        probe(32'h0090_0000, 0, 1, 32'h0090_0000, "R12 decode");
        probe(32'h0440_0000, 0, 0, 32'h0, "R12 window");
    endtask

    // R4, R5, R6: configuration rule violations.
    task automatic t_errors();
        chk_err(1'b0, "R6 clean");
        wr(3'd1, word(1, 3'd6, 12'd8));
        chk_err(1'b1, "R4");
        probe(32'h0080_0000, 0, 1, 32'h0080_0000, "R4 no match");
        wr(3'd1, word(1, 3'd1, 12'd9));
        chk_err(1'b1, "R5 misaligned");
        wr(3'd1, word(1, 3'd1, 12'd8));
        chk_err(1'b0, "R5 aligned");
        wr(3'd0, word(1, 3'd0, 12'd0));
        chk_err(1'b1, "R5 base zero");
        wr(3'd0, word(1, 3'd0, 12'd16));
        chk_err(1'b1, "R6 low above mid");
        wr(3'd1, word(0, 3'd1, 12'd8));
        chk_err(1'b0, "R6 disabled ignored");
    endtask

    // R2: writes to unused selects change nothing.
    task automatic t_ignored();
        probe(32'h0100_0000, 1, 0, 32'h0, "R2 before");
        wr(3'd5, 16'hFFFF);
        wr(3'd4, 16'h8001);
        chk_err(1'b0, "R2 ignored sel");
        probe(32'h0100_0000, 1, 0, 32'h0, "R2 ignored sel");
        probe(32'h0440_0000, 0, 0, 32'h0, "R2 ignored sel");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_top();
        t_gaps();
        t_reclaim();
        t_overlap();
        t_disable();
        t_errors();
        t_ignored();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule